// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame's destination address falls into one of 256 group-address bins that software has enabled. The six destination bytes arrive one per cycle in wire order. A CRC-32 is folded over them as they arrive. One cycle after the sixth byte, the block raises a one-cycle result strobe together with an accept flag.

The 256 bins sit in eight 32-bit table words. A plain register port reads and writes these words, and all of them are zero out of reset. The same byte stream can also carry a set or clear command instead of a lookup. The block then hashes the streamed address and sets or clears only the single bin that address maps to. Software can enable a group address without working out its hash.

Only group addresses can be accepted. An address whose first byte has its least significant bit clear always returns a strobe with the accept flag low.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash is computed over the six address bytes, each byte least significant bit first:
  - the register starts at all ones;
  - for each bit, feedback = register[31] XOR data bit, the register shifts left by one, and it is XORed with 0x04C11DB7 when the feedback is 1;
  - there is no final inversion.
  The bin number is bits 31..24 of the result.
- R2: Bin b lives in table word b[7:5], at bit position 31 - b[4:0]. Bin 0 is bit 31 of word 0 and bin 255 is bit 0 of word 7.
- R3: For a lookup (in_op = 2'b00 or 2'b11 on the first byte), match_valid is high for exactly the one cycle after the clock edge that takes the sixth byte. It stays low at all other times, including for set and clear commands.
- R4: match_hit is 1 only when the first address byte has bit 0 set and the table bit of the address's bin is 1. When match_valid is high and either condition fails, match_hit is 0.
- R5: A set command (in_op = 2'b01) or clear command (in_op = 2'b10) writes 1 or 0 into the bin of the streamed address at the edge that takes the sixth byte. Every other table bit is unchanged. The command applies whatever the group bit of the address is.
- R6: Synchronous reset clears all table words, reg_rdata, match_valid and match_hit to zero.
- R7: A register-port write replaces the word at reg_addr at the next edge. reg_rdata shows the word addressed by reg_addr one cycle after the address is presented.
- R8: A byte with in_first set always starts a new address, dropping any partial one. Bytes with in_valid high and in_first low are ignored when no address is in progress. in_valid low pauses the stream without losing progress.
- R9: If a register-port write and a set/clear command hit the same word in the same cycle, the word takes the register-port data. If they hit different words, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address byte valid |
| in_first | input | 1 | Marks the first byte of an address |
| in_op | input | 2 | Operation, sampled on the first byte: 00 lookup, 01 set, 10 clear, 11 lookup |
| in_byte | input | 8 | Address byte, wire order |
| match_valid | output | 1 | One-cycle lookup result strobe |
| match_hit | output | 1 | Address accepted by the filter |
| reg_we | input | 1 | Table word write enable |
| reg_addr | input | 3 | Table word select |
| reg_wdata | input | 32 | Table word write data |
| reg_rdata | output | 32 | Table word read data, one cycle latency |

## Verification
Several hundred pseudo-random addresses are checked against an arithmetic model of the hash and the bin mapping. If the bit order within a byte, the MSB-first position inside a word or the word select were wrong, accepts would scatter to the wrong bins and the model would disagree.

The bench checks four corner cases:
- An address with a clear group bit whose bin is enabled, which an unqualified design would accept.
- A restart in mid-address and stray bytes with no address in progress, which a design with a loose byte counter would turn into spurious or shifted results.
- A register write and a command landing on the same word in the same cycle, where a wrong priority leaves the command's bit merged into the written data.
- Writes to different words in the same cycle, where a wrong priority drops one of the two updates.

// File: rtl/mhf_pkg.sv
`timescale 1ns/1ps
package mhf_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_ALTLK  = 2'b11
  } hash_op_e;

  localparam int          CRC_W    = 32;
  localparam int          BYTE_W   = 8;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // Fold one byte into the running remainder, least significant data bit first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] cur,
                                                     input logic [BYTE_W-1:0] data);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = cur;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[CRC_W-1] ^ data[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/mhf_crc_unit.sv
`timescale 1ns/1ps
module mhf_crc_unit
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BIN_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              fin,
  output logic [BIN_W-1:0]  fin_bin
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_nxt;
  logic             take;

  always_comb begin
    take     = in_valid && (in_first || (cnt_q != '0));
    crc_base = in_first ? CRC_SEED : crc_q;
    crc_nxt  = crc_fold_byte(crc_base, in_byte);
    if (in_first) fin = in_valid && (ADDR_BYTES == 1);
    else          fin = take && (cnt_q == LAST_CNT);
    fin_bin  = crc_nxt[CRC_W-1 -: BIN_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      crc_q <= CRC_SEED;
    end else if (take) begin
      crc_q <= crc_nxt;
      if (fin)           cnt_q <= '0;
      else if (in_first) cnt_q <= ONE_CNT;
      else               cnt_q <= cnt_q + ONE_CNT;
    end
  end

endmodule

// File: rtl/mhf_table.sv
`timescale 1ns/1ps
module mhf_table #(
  parameter int TBL_WORDS = 8,
  parameter int WORD_W    = 32,
  parameter int BIN_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(TBL_WORDS)-1:0] wr_sel,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic [$clog2(TBL_WORDS)-1:0] rd_sel,
  output logic [WORD_W-1:0]           rd_data,
  input  logic                        upd_en,
  input  logic                        upd_val,
  input  logic [BIN_W-1:0]            upd_bin,
  input  logic [BIN_W-1:0]            look_bin,
  output logic                        look_bit,
  output logic [TBL_WORDS*WORD_W-1:0] flat
);

  localparam int SEL_W = $clog2(TBL_WORDS);
  localparam int POS_W = $clog2(WORD_W);
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(WORD_W - 1);

  logic [TBL_WORDS-1:0][WORD_W-1:0] words;
  logic [SEL_W-1:0] upd_sel, look_sel;
  logic [POS_W-1:0] upd_pos, look_pos;

  // Bins are numbered from the most significant bit of each word.
  always_comb begin
    upd_sel  = upd_bin[BIN_W-1 -: SEL_W];
    upd_pos  = TOP_POS - upd_bin[POS_W-1:0];
    look_sel = look_bin[BIN_W-1 -: SEL_W];
    look_pos = TOP_POS - look_bin[POS_W-1:0];
    look_bit = words[look_sel][look_pos];
  end

  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(w))) begin
        word_q <= wr_data;
      end else if (upd_en && (upd_sel == SEL_W'(w))) begin
        word_q[upd_pos] <= upd_val;
      end
    end
    assign words[w] = word_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= words[rd_sel];
  end

  assign flat = words;

endmodule

// File: rtl/mcast_hash_filter.sv
`timescale 1ns/1ps
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int TBL_WORDS  = 8,
  parameter int WORD_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         in_first,
  input  logic [1:0]                   in_op,
  input  logic [7:0]                   in_byte,
  output logic                         match_valid,
  output logic                         match_hit,
  input  logic                         reg_we,
  input  logic [$clog2(TBL_WORDS)-1:0] reg_addr,
  input  logic [WORD_W-1:0]            reg_wdata,
  output logic [WORD_W-1:0]            reg_rdata
);

  localparam int BIN_W = $clog2(TBL_WORDS * WORD_W);

  hash_op_e              op_q, op_cur;
  logic                  grp_q, grp_cur;
  logic                  fin;
  logic [BIN_W-1:0]      fin_bin;
  logic                  look_bit;
  logic                  is_look;
  logic                  upd_en, upd_val;
  logic [TBL_WORDS*WORD_W-1:0] tbl_flat;

  mhf_crc_unit #(
    .ADDR_BYTES(ADDR_BYTES),
    .BIN_W     (BIN_W)
  ) u_crc (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_first(in_first),
    .in_byte (in_byte),
    .fin     (fin),
    .fin_bin (fin_bin)
  );

  always_comb begin
    op_cur  = in_first ? hash_op_e'(in_op) : op_q;
    grp_cur = in_first ? in_byte[0] : grp_q;
    is_look = (op_cur == OP_LOOKUP) || (op_cur == OP_ALTLK);
    upd_en  = fin && !is_look;
    upd_val = (op_cur == OP_SET);
  end

  mhf_table #(
    .TBL_WORDS(TBL_WORDS),
    .WORD_W   (WORD_W),
    .BIN_W    (BIN_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_we),
    .wr_sel  (reg_addr),
    .wr_data (reg_wdata),
    .rd_sel  (reg_addr),
    .rd_data (reg_rdata),
    .upd_en  (upd_en),
    .upd_val (upd_val),
    .upd_bin (fin_bin),
    .look_bin(fin_bin),
    .look_bit(look_bit),
    .flat    (tbl_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q        <= OP_LOOKUP;
      grp_q       <= 1'b0;
      match_valid <= 1'b0;
      match_hit   <= 1'b0;
    end else begin
      if (in_valid && in_first) begin
        op_q  <= hash_op_e'(in_op);
        grp_q <= in_byte[0];
      end
      match_valid <= fin && is_look;
      match_hit   <= fin && is_look && grp_cur && look_bit;
    end
  end

endmodule

// File: rtl/mhf_checker.sv
`timescale 1ns/1ps
module mhf_checker #(
  parameter int TBL_WORDS = 8,
  parameter int WORD_W    = 32,
  parameter int BIN_W     = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic                         in_first,
  input logic [7:0]                   in_byte,
  input logic                         match_valid,
  input logic                         match_hit,
  input logic                         reg_we,
  input logic [$clog2(TBL_WORDS)-1:0] reg_addr,
  input logic [WORD_W-1:0]            reg_wdata,
  input logic                         upd_en,
  input logic [BIN_W-1:0]             upd_bin,
  input logic [TBL_WORDS*WORD_W-1:0]  tbl_flat
);

  localparam int SEL_W = $clog2(TBL_WORDS);

  logic grp_seen_q;
  always_ff @(posedge clk) begin
    if (rst)                        grp_seen_q <= 1'b0;
    else if (in_valid && in_first)  grp_seen_q <= in_byte[0];
  end

  p_zero_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tbl_flat == '0));

  p_strobe_follows_byte_r3: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> $past(in_valid));

  p_strobe_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    match_valid |=> !match_valid);

  p_hit_needs_group_r4: assert property (@(posedge clk) disable iff (rst)
    match_hit |-> (match_valid && grp_seen_q));

  p_single_bin_update_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !reg_we) |=> ($countones(tbl_flat ^ $past(tbl_flat)) <= 1));

  p_port_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_we && upd_en && (upd_bin[BIN_W-1 -: SEL_W] == reg_addr))
    |=> (tbl_flat[$past(reg_addr)*WORD_W +: WORD_W] == $past(reg_wdata)));

endmodule

bind mcast_hash_filter mhf_checker #(
  .TBL_WORDS(TBL_WORDS),
  .WORD_W   (WORD_W),
  .BIN_W    (BIN_W)
) u_mhf_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_first   (in_first),
  .in_byte    (in_byte),
  .match_valid(match_valid),
  .match_hit  (match_hit),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .upd_en     (upd_en),
  .upd_bin    (fin_bin),
  .tbl_flat   (tbl_flat)
);

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_first = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic [7:0]  in_byte = 8'h00;
  logic        match_valid, match_hit;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [8];
  logic [63:0] seed = 64'h0123_4567_89AB_CDEF;
  logic [47:0] saved [24];

  always #2.5 clk = ~clk;

  mcast_hash_filter u_mcast_hash_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_op(in_op), .in_byte(in_byte), .match_valid(match_valid),
    .match_hit(match_hit), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Hash model: reflected byte order, MSB-aligned shift register, no final inversion.
  function automatic logic [7:0] bin_of(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47 - 8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[31] ^ b[j];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c[31:24];
  endfunction

  function automatic logic model_bit(input logic [7:0] b);
    return model[b[7:5]][31 - b[4:0]];
  endfunction

  task automatic next_addr(output logic [47:0] a);
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    a = seed[63:16];
  endtask

  task automatic send(input logic [1:0] op, input logic [47:0] a, input int gap,
                      output logic mv, output logic mh);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (i == 0); in_op = op; in_byte = a[47 - 8*i -: 8];
      if (gap > 0 && i < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (match_valid) chk(1'b0, "R3 strobe during address", 1, 0);
          in_valid = 1'b0; in_first = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    mv = match_valid; mh = match_hit;
    @(negedge clk);
    if (match_valid) chk(1'b0, "R3 strobe longer than one cycle", 1, 0);
  endtask

  task automatic rd_word(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wr_word(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
    model[a] = d;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [47:0] a, b;
    logic mv, mh;
    logic [31:0] d;
    logic [7:0] bn;

    for (int w = 0; w < 8; w++) model[w] = 32'h0;
    repeat (4) @(negedge clk);
    chk(match_valid == 1'b0 && match_hit == 1'b0, "R6 outputs in reset",
        {30'h0, match_valid, match_hit}, 0);
    rst = 1'b0;

    // R6: empty table after reset, no accept
    for (int w = 0; w < 8; w++) begin
      rd_word(3'(w), d);
      chk(d == 32'h0, "R6 word zero after reset", d, 0);
    end
    next_addr(a); a[40] = 1'b1;
    send(2'b00, a, 0, mv, mh);
    chk(mv && !mh, "R6 R3 empty table rejects", {30'h0, mv, mh}, 32'h2);

    // R5 R1 R2: set bins via command, then look them up
    for (int i = 0; i < 48; i++) begin
      next_addr(a); a[40] = 1'b1;
      if (i < 24) saved[i] = a;
      bn = bin_of(a);
      send(2'b01, a, i % 3, mv, mh);
      chk(!mv, "R3 no strobe for set command", {31'h0, mv}, 0);
      model[bn[7:5]][31 - bn[4:0]] = 1'b1;
      rd_word(bn[7:5], d);
      chk(d == model[bn[7:5]], "R5 R2 word after set", d, model[bn[7:5]]);
      send(2'b00, a, 0, mv, mh);
      chk(mv && mh, "R1 R4 set address accepted", {30'h0, mv, mh}, 32'h3);
    end

    // R1 R2 R3: random group lookups against model
    for (int i = 0; i < 200; i++) begin
      next_addr(a); a[40] = 1'b1;
      send((i % 2 == 0) ? 2'b00 : 2'b11, a, i % 2, mv, mh);
      chk(mv && (mh == model_bit(bin_of(a))), "R1 R2 lookup vs model",
          {30'h0, mv, mh}, {30'h0, 1'b1, model_bit(bin_of(a))});
    end

    // R4: individual address whose bin is enabled is still rejected
    for (int i = 0; i < 4; i++) begin
      next_addr(a); a[40] = 1'b0;
      bn = bin_of(a);
      send(2'b01, a, 0, mv, mh);
      model[bn[7:5]][31 - bn[4:0]] = 1'b1;
      send(2'b00, a, 0, mv, mh);
      chk(mv && !mh, "R4 non-group address rejected", {30'h0, mv, mh}, 32'h2);
      b = a; b[40] = 1'b1;
      if (bin_of(b) == bn) begin
        send(2'b00, b, 0, mv, mh);
        chk(mv && mh, "R4 group twin accepted", {30'h0, mv, mh}, 32'h3);
      end
    end

    // R5: clear command removes only its bin
    for (int i = 0; i < 24; i++) begin
      bn = bin_of(saved[i]);
      send(2'b10, saved[i], 0, mv, mh);
      model[bn[7:5]][31 - bn[4:0]] = 1'b0;
      rd_word(bn[7:5], d);
      chk(d == model[bn[7:5]], "R5 word after clear", d, model[bn[7:5]]);
      send(2'b00, saved[i], 0, mv, mh);
      chk(mv && !mh, "R5 cleared address rejected", {30'h0, mv, mh}, 32'h2);
    end

    // R7 R2: register port writes, read back, sweep lookups
    for (int w = 0; w < 8; w++) wr_word(3'(w), 32'hA5C3_0F96 ^ (32'(w) * 32'h0123_4567));
    for (int w = 0; w < 8; w++) begin
      rd_word(3'(w), d);
      chk(d == model[w], "R7 register readback", d, model[w]);
    end
    for (int i = 0; i < 300; i++) begin
      next_addr(a); a[40] = 1'b1;
      send(2'b00, a, 0, mv, mh);
      chk(mv && (mh == model_bit(bin_of(a))), "R2 R7 lookup after writes",
          {30'h0, mv, mh}, {30'h0, 1'b1, model_bit(bin_of(a))});
    end

    // R8: restart in mid-address
    next_addr(b); b[40] = 1'b1;
    next_addr(a); a[40] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (i == 0); in_op = 2'b00; in_byte = b[47 - 8*i -: 8];
    end
    send(2'b00, a, 0, mv, mh);
    chk(mv && (mh == model_bit(bin_of(a))), "R8 restart uses new address",
        {30'h0, mv, mh}, {30'h0, 1'b1, model_bit(bin_of(a))});
    // R8: stray bytes while idle produce nothing
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = 1'b0; in_op = 2'b01; in_byte = 8'(i * 37);
    end
    @(negedge clk); in_valid = 1'b0;
    mv = match_valid;
    @(negedge clk);
    chk(!mv && !match_valid, "R8 stray bytes ignored", {31'h0, mv | match_valid}, 0);
    for (int w = 0; w < 8; w++) begin
      rd_word(3'(w), d);
      chk(d == model[w], "R8 table untouched by stray bytes", d, model[w]);
    end

    // R9: same-word collision, then different-word collision
    for (int k = 0; k < 2; k++) begin
      logic [2:0] ws, wo;
      next_addr(a); a[40] = 1'b1;
      bn = bin_of(a);
      ws = bn[7:5];
      wo = (k == 0) ? ws : ws ^ 3'd1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        in_valid = 1'b1; in_first = (i == 0); in_op = 2'b01; in_byte = a[47 - 8*i -: 8];
        if (i == 5) begin
          reg_we = 1'b1; reg_addr = wo;
          reg_wdata = ~(32'h1 << (31 - bn[4:0])) & 32'h3C3C_5A5A;
        end
      end
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; reg_we = 1'b0;
      model[wo] = ~(32'h1 << (31 - bn[4:0])) & 32'h3C3C_5A5A;
      if (k == 1) model[ws][31 - bn[4:0]] = 1'b1;
      rd_word(wo, d);
      chk(d == model[wo], "R9 register write data kept", d, model[wo]);
      rd_word(ws, d);
      chk(d == model[ws], "R9 command word outcome", d, model[ws]);
    end

    finish_run();
  end

endmodule